// File: doc/BRIEF.md
# Configurable Sum-of-Products Classifier

This block sorts a 16-bit feature word into one of eight categories using a programmable two-level logic array. The feature word is four channels of 4 bits. Each feature bit is offered to the first plane both as itself and inverted, which gives 32 candidate lines. Every one of 53 product terms takes the AND of whichever of those lines its configuration selects. A second plane gives each category an OR output that collects whichever product terms its configuration selects.

A priority stage turns the eight OR outputs into a 3-bit category number and a valid flag, and both are registered. When several categories fire together, the lowest-numbered one wins. The whole fuse map is one flat 2120-bit configuration word. It is loaded one bit per cycle through a shift port with an enable, so an external search engine can write a candidate configuration and then score it.

Top module: `sop_classifier`

## Requirements
- R1: `feature_i` is 16 bits (channel k in bits 4k+3..4k). Candidate line l for l in 0..15 is feature bit l, and line 16+l is the complement of feature bit l.
- R2: The configuration word is 2120 bits. Bit t*32+l connects line l to product term t (t in 0..52). Bit 1696+c*53+t connects product term t to category output c (c in 0..7).
- R3: A product term is 1 exactly when at least one line is connected to it and every connected line is 1. A term with no connected line is 0.
- R4: Category output c is 1 when at least one product term connected to it is 1.
- R5: When several category outputs are 1, `class_o` gives the lowest index among them.
- R6: When no category output is 1, `valid_o` is 0 and `class_o` is 0. Otherwise `valid_o` is 1.
- R7: On each clock edge with `cfg_en_i` high, `cfg_bit_i` enters at bit 2119 and the word moves one place toward bit 0. The first of 2120 consecutive bits therefore lands at bit 0. With `cfg_en_i` low, `cfg_bit_i` has no effect.
- R8: `class_o` and `valid_o` reflect the feature word and configuration present before the previous rising clock edge, which is one cycle of latency.
- R9: While `rst_ni` is low, the configuration word is all zero and `valid_o` and `class_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Shift enable for the configuration word |
| cfg_bit_i | input | 1 | Serial configuration bit |
| feature_i | input | 16 | Feature word, four 4-bit channels |
| class_o | output | 3 | Category index, registered |
| valid_o | output | 1 | At least one category fired, registered |

## Verification
A configuration bit that is stuck, misplaced or shifted in the wrong order makes a product term fire for the wrong input pattern, or stay silent for the right one. This appears in the registered category one cycle after the offending feature word. The full feature space is swept against a hand-built map that crosses priority, complement lines and contradictory terms, and against pseudo-random sparse maps. A layout error in either plane therefore shows as a wrong category within the sweep. A shift path that reacts while disabled shows on the next classification, because the bench re-checks after toggling the serial bit with the enable low.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned FEAT_W_DEF  = 16;
  localparam int unsigned TERMS_DEF   = 53;
  localparam int unsigned CLASSES_DEF = 8;
endpackage

// File: rtl/sop_cfg_shreg.sv
module sop_cfg_shreg #(
  parameter int unsigned G = 2120
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [G-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (en_i) word_o <= {bit_i, word_o[G-1:1]};
  end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int unsigned LINES = 32,
  parameter int unsigned TERMS = 53
) (
  input  logic [LINES-1:0]       lines_i,
  input  logic [TERMS*LINES-1:0] fuse_i,
  output logic [TERMS-1:0]       term_o
);
  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic [LINES-1:0] mask;
    assign mask = fuse_i[t*LINES +: LINES];
    // empty term never fires
    assign term_o[t] = (|mask) & (&(lines_i | ~mask));
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int unsigned TERMS   = 53,
  parameter int unsigned CLASSES = 8
) (
  input  logic [TERMS-1:0]         term_i,
  input  logic [CLASSES*TERMS-1:0] fuse_i,
  output logic [CLASSES-1:0]       hit_o
);
  for (genvar c = 0; c < CLASSES; c++) begin : g_cls
    assign hit_o[c] = |(term_i & fuse_i[c*TERMS +: TERMS]);
  end
endmodule

// File: rtl/sop_prio.sv
module sop_prio #(
  parameter int unsigned CLASSES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [CLASSES-1:0] hit_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = CLASSES - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |hit_i;
  end
endmodule

// File: rtl/sop_classifier.sv
module sop_classifier #(
  parameter int unsigned FEAT_W  = sop_pkg::FEAT_W_DEF,
  parameter int unsigned TERMS   = sop_pkg::TERMS_DEF,
  parameter int unsigned CLASSES = sop_pkg::CLASSES_DEF,
  localparam int unsigned LINES  = 2 * FEAT_W,
  localparam int unsigned AND_G  = LINES * TERMS,
  localparam int unsigned OR_G   = CLASSES * TERMS,
  localparam int unsigned G      = AND_G + OR_G,
  localparam int unsigned IDX_W  = (CLASSES > 1) ? $clog2(CLASSES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_bit_i,
  input  logic [FEAT_W-1:0] feature_i,
  output logic [IDX_W-1:0]  class_o,
  output logic              valid_o
);
  logic [G-1:0]       genome;
  logic [TERMS-1:0]   term;
  logic [CLASSES-1:0] hit;
  logic [IDX_W-1:0]   idx;
  logic               any;

  sop_cfg_shreg #(.G(G)) i_cfg (
    .clk_i, .rst_ni, .en_i(cfg_en_i), .bit_i(cfg_bit_i), .word_o(genome)
  );

  sop_and_plane #(.LINES(LINES), .TERMS(TERMS)) i_and (
    .lines_i({~feature_i, feature_i}),
    .fuse_i (genome[AND_G-1:0]),
    .term_o (term)
  );

  sop_or_plane #(.TERMS(TERMS), .CLASSES(CLASSES)) i_or (
    .term_i(term),
    .fuse_i(genome[G-1:AND_G]),
    .hit_o (hit)
  );

  sop_prio #(.CLASSES(CLASSES), .IDX_W(IDX_W)) i_prio (
    .hit_i(hit), .idx_o(idx), .any_o(any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      class_o <= '0;
      valid_o <= 1'b0;
    end else begin
      class_o <= idx;
      valid_o <= any;
    end
  end
endmodule

// File: rtl/sop_classifier_chk.sv
module sop_classifier_chk #(
  parameter int unsigned G       = 2120,
  parameter int unsigned CLASSES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_en_i,
  input logic               cfg_bit_i,
  input logic [G-1:0]       genome,
  input logic [CLASSES-1:0] hit,
  input logic [IDX_W-1:0]   class_o,
  input logic               valid_o
);
  logic [CLASSES-1:0] hit_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= '0;
    else         hit_q <= hit;
  end

  p_valid_follows_hits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (|hit_q));

  p_idle_class_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> class_o == '0);

  p_lowest_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hit_q[class_o] && ((hit_q & ((CLASSES'(1) << class_o) - CLASSES'(1))) == '0)));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(genome));

  p_cfg_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> genome[G-1] == $past(cfg_bit_i));
endmodule

bind sop_classifier sop_classifier_chk #(
  .G(G), .CLASSES(CLASSES), .IDX_W(IDX_W)
) i_chk (
  .clk_i, .rst_ni, .cfg_en_i, .cfg_bit_i,
  .genome(genome), .hit(hit), .class_o, .valid_o
);

// File: tb/test_sop_classifier.sv
module test_sop_classifier;
  localparam int CLK_P = 10;
  localparam int FW = 16, NT = 53, NC = 8, NL = 32;
  localparam int ANDG = NL * NT, GW = ANDG + NC * NT;

  logic clk_i = 0, rst_ni = 0, cfg_en_i = 0, cfg_bit_i = 0;
  logic [FW-1:0] feature_i = '0;
  logic [2:0] class_o;
  logic valid_o;
  logic [GW-1:0] gen;
  int checks = 0, errors = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_P/2) clk_i = ~clk_i;

  sop_classifier i_sop_classifier (.*);

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic void model(input logic [FW-1:0] f, output logic [2:0] c, output logic v);
    logic [NL-1:0] ln;
    logic [NT-1:0] tm;
    logic [NC-1:0] h;
    ln = {~f, f};
    for (int t = 0; t < NT; t++) begin
      logic has, ok;
      has = 0; ok = 1;
      for (int l = 0; l < NL; l++)
        if (gen[t*NL + l]) begin has = 1; if (!ln[l]) ok = 0; end
      tm[t] = has & ok;
    end
    h = '0;
    for (int k = 0; k < NC; k++)
      for (int t = 0; t < NT; t++)
        if (gen[ANDG + k*NT + t] && tm[t]) h[k] = 1;
    v = |h; c = 0;
    for (int k = NC - 1; k >= 0; k--) if (h[k]) c = 3'(k);
  endfunction

  task automatic load();
    for (int i = 0; i < GW; i++) begin
      @(negedge clk_i); cfg_en_i = 1; cfg_bit_i = gen[i];
    end
    @(negedge clk_i); cfg_en_i = 0; cfg_bit_i = 0;
  endtask

  task automatic check(input string req, input logic [2:0] ec, input logic ev);
    checks++;
    if (valid_o !== ev || class_o !== ec) begin
      errors++;
      $display("FAIL %s: feature %h actual valid=%b class=%0d expected valid=%b class=%0d",
               req, feature_i, valid_o, class_o, ev, ec);
    end
  endtask

  // drive each word at a negedge, check the registered result one negedge later (R8)
  task automatic sweep(input string req, input int n, input int stride);
    logic [2:0] ec; logic ev;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      feature_i = 16'(i * stride);
      model(feature_i, ec, ev);
      @(negedge clk_i);
      check(req, ec, ev);
    end
  endtask

  task automatic set_term(input int t, input int l);
    gen[t*NL + l] = 1;
  endtask
  task automatic set_or(input int c, input int t);
    gen[ANDG + c*NT + t] = 1;
  endtask

  initial begin
    // R9: reset state
    #(CLK_P * 2);
    @(negedge clk_i);
    check("R9 reset", 3'd0, 1'b0);
    rst_ni = 1;
    gen = '0;
    sweep("R9 R3 empty map", 64, 1021);

    // hand map: term c matches channel0 == c, feeds output c
    gen = '0;
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < 4; b++) set_term(c, ((c >> b) & 1) ? b : 16 + b);
      set_or(c, c);
    end
    set_term(8, 15); set_or(2, 8); set_or(5, 8);          // R5 priority overlap
    set_term(9, 0); set_term(9, 16); set_or(7, 9);         // R3 contradictory term
    set_or(6, 52);                                         // R3 empty term wired
    set_term(10, 19); set_term(10, 4); set_or(0, 10);      // R1 complement line
    load();
    sweep("R1 R2 R4 R5 R6 hand map exhaustive", 65536, 1);

    // R7: toggling serial bit with enable low changes nothing
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); cfg_bit_i = ~cfg_bit_i;
    end
    cfg_bit_i = 0;
    sweep("R7 hold while disabled", 512, 127);

    // pseudo-random sparse maps
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < GW; i++) begin
        lfsr = step(lfsr);
        gen[i] = (i < ANDG) ? (lfsr[3:0] == 4'd0) : (lfsr[2:0] == 3'd0);
      end
      load();
      sweep("R2 R3 R4 R5 random map", 8192, 8 + m);
    end

    // R9: asynchronous reset clears map and outputs
    @(negedge clk_i); rst_ni = 0;
    #1 check("R9 async clear", 3'd0, 1'b0);
    @(negedge clk_i); rst_ni = 1;
    gen = '0;
    sweep("R9 map cleared", 64, 997);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule